// File: doc/BRIEF.md
# Object Migration Controller

This block tracks the residency of one shared object in one site's local attraction memory. It handles creation, deletion and migration of that object between sites. A local evict command, together with a destination site chosen elsewhere, sends the object away. Messages from the network can inject a copy, acknowledge an arrival, or delete the object. The block answers by emitting inject and acknowledge messages of its own.

When an exclusive or canonical copy is evicted, the local copy does not vanish at once. It enters a transient Leaving state and stays there until the receiving site confirms arrival, so at least one copy of the object exists somewhere at all times. While the copy is Leaving, every other message addressed to the object is passed on, unchanged, to the new site. Every response appears on the transmit port one clock after the event that causes it.

Top module: `obj_migrate_fsm`

## Requirements
- R1: After reset, `state_o` reads Invalid and both `tx_valid_o` and `err_o` are low. State codes are 0 Invalid, 1 Clone, 2 Original, 3 Exclusive and 4 Leaving.
- R2: A local evict while the state is Invalid or Clone leaves the state Invalid and sends no message.
- R3: A local evict while the state is Exclusive or Original moves the state to Leaving. On the next cycle it emits an inject message (kind 1) to `evict_dest_i`, with tag 0 for Exclusive or tag 1 for Original, and zero data.
- R4: An acknowledge (kind 2) received while Leaving moves the state to Invalid and sends nothing.
- R5: While Leaving, any received message other than an acknowledge is sent on the next cycle to the stored destination, with kind, tag and data unchanged, and the state stays Leaving.
- R6: An inject with tag 0 (Exclusive) or tag 1 (Original), received while the state is Invalid or Clone, installs that state. It also returns an acknowledge (kind 2) to `rx_src_i`, carrying the installed tag.
- R7: An inject with any other tag, received while the state is Invalid, installs Clone and sends no reply. While the state is Clone, such an inject has no effect.
- R8: A delete (kind 3) received in Exclusive, Original or Clone moves the state to Invalid and sends nothing.
- R9: A local evict while Leaving is ignored. The state stays Leaving, no message is sent, and the stored destination is kept.
- R10: An acknowledge received outside Leaving raises `err_o` for one cycle, leaves the state unchanged and sends nothing.
- R11: When a message arrives in the same cycle as a local evict, the message is handled and the evict is dropped.
- R12: An inject received while the state is Exclusive or Original leaves the state unchanged, sends nothing and raises `err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_i | input | 1 | Local command to evict the object |
| evict_dest_i | input | SITE_W | Site chosen to receive an evicted object |
| rx_valid_i | input | 1 | A message for this object is present |
| rx_kind_i | input | 2 | Message kind: 0 other, 1 inject, 2 acknowledge, 3 delete |
| rx_tag_i | input | 2 | State tag carried by the message |
| rx_src_i | input | SITE_W | Site that sent the message |
| rx_data_i | input | DATA_W | Message payload |
| tx_valid_o | output | 1 | Outgoing message present |
| tx_kind_o | output | 2 | Outgoing message kind |
| tx_tag_o | output | 2 | Outgoing state tag |
| tx_dest_o | output | SITE_W | Outgoing destination site |
| tx_data_o | output | DATA_W | Outgoing payload |
| state_o | output | 3 | Current residency state |
| err_o | output | 1 | One-cycle pulse on an unexpected message |

## Verification
A chain of vectors walks the object through full migrations. One migration starts from an injected Exclusive copy. Another starts from a Clone that is upgraded to Original. Each migration ends with its acknowledgement. This separates the Exclusive and Original inject tags, and separates forwarding from local handling. Messages of every kind are sent while the copy is Leaving, which shows that only the acknowledge is consumed. The same messages sent in other states tell legal transitions apart from those that raise the error flag. A vector that presents an evict and a message together shows which of the two wins, and a reset in the middle of the sequence confirms the idle state.

// File: rtl/obj_migrate_fsm.sv
module obj_migrate_fsm #(
  parameter int SITE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_i,
  input  logic [SITE_W-1:0] evict_dest_i,
  input  logic              rx_valid_i,
  input  logic [1:0]        rx_kind_i,
  input  logic [1:0]        rx_tag_i,
  input  logic [SITE_W-1:0] rx_src_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  output logic [1:0]        tx_kind_o,
  output logic [1:0]        tx_tag_o,
  output logic [SITE_W-1:0] tx_dest_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [2:0]        state_o,
  output logic              err_o
);

  typedef enum logic [2:0] {S_INV = 3'd0, S_CLN = 3'd1, S_ORG = 3'd2,
                            S_EXC = 3'd3, S_LEV = 3'd4} st_e;
  localparam logic [1:0] K_OTH = 2'd0, K_INJ = 2'd1, K_ACK = 2'd2, K_DEL = 2'd3;
  localparam logic [1:0] T_EXC = 2'd0, T_ORG = 2'd1;

  st_e               st_q, st_n;
  logic [SITE_W-1:0] dst_q, dst_n;
  logic              txv_n, err_n;
  logic [1:0]        kind_n, tag_n;
  logic [SITE_W-1:0] dest_n;
  logic [DATA_W-1:0] data_n;

  wire holds_owner = (st_q == S_EXC) || (st_q == S_ORG);

  always_comb begin
    st_n   = st_q;
    dst_n  = dst_q;
    txv_n  = 1'b0;
    kind_n = K_OTH;
    tag_n  = 2'd0;
    dest_n = '0;
    data_n = '0;
    err_n  = 1'b0;
    if (rx_valid_i) begin
      if (st_q == S_LEV) begin
        if (rx_kind_i == K_ACK) begin
          st_n = S_INV;
        end else begin
          txv_n  = 1'b1;
          kind_n = rx_kind_i;
          tag_n  = rx_tag_i;
          dest_n = dst_q;
          data_n = rx_data_i;
        end
      end else begin
        case (rx_kind_i)
          K_INJ: begin
            if (holds_owner) begin
              err_n = 1'b1;
            end else if (rx_tag_i == T_EXC || rx_tag_i == T_ORG) begin
              st_n   = (rx_tag_i == T_EXC) ? S_EXC : S_ORG;
              txv_n  = 1'b1;
              kind_n = K_ACK;
              tag_n  = rx_tag_i;
              dest_n = rx_src_i;
            end else begin
              st_n = S_CLN;
            end
          end
          K_ACK:   err_n = 1'b1;
          K_DEL:   st_n  = S_INV;
          default: ;
        endcase
      end
    end else if (evict_i) begin
      case (st_q)
        S_INV, S_CLN: st_n = S_INV;
        S_EXC, S_ORG: begin
          st_n   = S_LEV;
          dst_n  = evict_dest_i;
          txv_n  = 1'b1;
          kind_n = K_INJ;
          tag_n  = (st_q == S_EXC) ? T_EXC : T_ORG;
          dest_n = evict_dest_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_INV;
      dst_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_kind_o  <= K_OTH;
      tx_tag_o   <= 2'd0;
      tx_dest_o  <= '0;
      tx_data_o  <= '0;
      err_o      <= 1'b0;
    end else begin
      st_q       <= st_n;
      dst_q      <= dst_n;
      tx_valid_o <= txv_n;
      tx_kind_o  <= kind_n;
      tx_tag_o   <= tag_n;
      tx_dest_o  <= dest_n;
      tx_data_o  <= data_n;
      err_o      <= err_n;
    end
  end

  assign state_o = st_q;

  a_r2_drop_no_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && evict_i && (state_o == 3'd0 || state_o == 3'd1))
    |=> (state_o == 3'd0 && !tx_valid_o));

  a_r3_evict_inject: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && evict_i && (state_o == 3'd2 || state_o == 3'd3))
    |=> (state_o == 3'd4 && tx_valid_o && tx_kind_o == 2'd1
         && tx_dest_o == $past(evict_dest_i)));

  a_r4_ack_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_kind_i == 2'd2 && state_o == 3'd4)
    |=> (state_o == 3'd0 && !tx_valid_o && !err_o));

  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_kind_i != 2'd2 && state_o == 3'd4)
    |=> (state_o == 3'd4 && tx_valid_o && tx_kind_o == $past(rx_kind_i)
         && tx_data_o == $past(rx_data_i)));

  a_r8_delete: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_kind_i == 2'd3 && state_o != 3'd4)
    |=> (state_o == 3'd0 && !tx_valid_o));

  a_r9_leave_ignores_evict: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && evict_i && state_o == 3'd4)
    |=> (state_o == 3'd4 && !tx_valid_o));

  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && rx_kind_i == 2'd2 && state_o != 3'd4)
    |=> (err_o && $stable(state_o) && !tx_valid_o));

endmodule

// File: tb/obj_migrate_fsm_test.sv
module obj_migrate_fsm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic       ev;
    logic [3:0] evd;
    logic       rv;
    logic [1:0] rk;
    logic [1:0] rt;
    logic [3:0] rs;
    logic [7:0] rd;
    logic [2:0] est;
    logic       etv;
    logic [1:0] etk;
    logic [1:0] ett;
    logic [3:0] etd;
    logic [7:0] etdata;
    logic       eerr;
    logic [3:0] req;
  } vec_t;

  // ev evd rv rk rt rs rd | est etv etk ett etd etdata eerr | req
  localparam vec_t VECS [NV] = '{
    '{1'b0,4'd0,1'b1,2'd1,2'd0,4'd5,8'h00, 3'd3,1'b1,2'd2,2'd0,4'd5,8'h00,1'b0, 4'd6 }, // R6
    '{1'b1,4'd9,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd4,1'b1,2'd1,2'd0,4'd9,8'h00,1'b0, 4'd3 }, // R3
    '{1'b1,4'd3,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd4,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd9 }, // R9
    '{1'b0,4'd0,1'b1,2'd0,2'd1,4'd2,8'hA5, 3'd4,1'b1,2'd0,2'd1,4'd9,8'hA5,1'b0, 4'd5 }, // R5
    '{1'b0,4'd0,1'b1,2'd3,2'd2,4'd2,8'h3C, 3'd4,1'b1,2'd3,2'd2,4'd9,8'h3C,1'b0, 4'd5 }, // R5
    '{1'b0,4'd0,1'b1,2'd2,2'd0,4'd9,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd4 }, // R4
    '{1'b0,4'd0,1'b1,2'd2,2'd0,4'd9,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b1, 4'd10}, // R10
    '{1'b0,4'd0,1'b1,2'd1,2'd2,4'd2,8'h00, 3'd1,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd7 }, // R7
    '{1'b0,4'd0,1'b1,2'd1,2'd1,4'd7,8'h00, 3'd2,1'b1,2'd2,2'd1,4'd7,8'h00,1'b0, 4'd6 }, // R6
    '{1'b0,4'd0,1'b1,2'd1,2'd0,4'd1,8'h00, 3'd2,1'b0,2'd0,2'd0,4'd0,8'h00,1'b1, 4'd12}, // R12
    '{1'b1,4'd4,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd4,1'b1,2'd1,2'd1,4'd4,8'h00,1'b0, 4'd3 }, // R3
    '{1'b0,4'd0,1'b1,2'd2,2'd0,4'd4,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd4 }, // R4
    '{1'b0,4'd0,1'b1,2'd1,2'd3,4'd2,8'h00, 3'd1,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd7 }, // R7
    '{1'b1,4'd6,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd2 }, // R2
    '{1'b1,4'd6,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd2 }, // R2
    '{1'b1,4'd8,1'b1,2'd1,2'd0,4'd3,8'h00, 3'd3,1'b1,2'd2,2'd0,4'd3,8'h00,1'b0, 4'd11}, // R11
    '{1'b0,4'd0,1'b1,2'd3,2'd0,4'd3,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd8 }, // R8
    '{1'b0,4'd0,1'b1,2'd1,2'd1,4'd1,8'h00, 3'd2,1'b1,2'd2,2'd1,4'd1,8'h00,1'b0, 4'd6 }, // R6
    '{1'b0,4'd0,1'b1,2'd3,2'd0,4'd1,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd8 }, // R8
    '{1'b0,4'd0,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0, 4'd1 }  // R1 idle
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evict_i = 1'b0;
  logic [3:0] evict_dest_i = '0;
  logic       rx_valid_i = 1'b0;
  logic [1:0] rx_kind_i = '0;
  logic [1:0] rx_tag_i = '0;
  logic [3:0] rx_src_i = '0;
  logic [7:0] rx_data_i = '0;
  logic       tx_valid_o;
  logic [1:0] tx_kind_o;
  logic [1:0] tx_tag_o;
  logic [3:0] tx_dest_o;
  logic [7:0] tx_data_o;
  logic [2:0] state_o;
  logic       err_o;

  int checks = 0;
  int failures = 0;

  obj_migrate_fsm #(.SITE_W(4), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .evict_i(evict_i), .evict_dest_i(evict_dest_i),
    .rx_valid_i(rx_valid_i), .rx_kind_i(rx_kind_i), .rx_tag_i(rx_tag_i),
    .rx_src_i(rx_src_i), .rx_data_i(rx_data_i), .tx_valid_o(tx_valid_o),
    .tx_kind_o(tx_kind_o), .tx_tag_o(tx_tag_o), .tx_dest_o(tx_dest_o),
    .tx_data_o(tx_data_o), .state_o(state_o), .err_o(err_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [22:0] pack_out();
    return {state_o, tx_valid_o, tx_kind_o, tx_tag_o, tx_dest_o, tx_data_o, err_o};
  endfunction

  task automatic check_out(input logic [22:0] exp, input int req, input int idx);
    checks++;
    if (pack_out() !== exp) begin
      failures++;
      $display("FAIL R%0d step %0d: actual=%h expected=%h", req, idx, pack_out(), exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    evict_i = v.ev; evict_dest_i = v.evd; rx_valid_i = v.rv;
    rx_kind_i = v.rk; rx_tag_i = v.rt; rx_src_i = v.rs; rx_data_i = v.rd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_out({3'd0, 1'b0, 2'd0, 2'd0, 4'd0, 8'h00, 1'b0}, 1, -1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_out({VECS[i].est, VECS[i].etv, VECS[i].etk, VECS[i].ett,
                 VECS[i].etd, VECS[i].etdata, VECS[i].eerr}, int'(VECS[i].req), i);
    end
    // R1: reset in the middle of a held Exclusive copy
    apply('{1'b0,4'd0,1'b1,2'd1,2'd0,4'd6,8'h00, 3'd3,1'b1,2'd2,2'd0,4'd6,8'h00,1'b0,4'd6});
    check_out({3'd3, 1'b1, 2'd2, 2'd0, 4'd6, 8'h00, 1'b0}, 6, 100);
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid_i = 1'b0;
    @(posedge clk);
    #1;
    check_out({3'd0, 1'b0, 2'd0, 2'd0, 4'd0, 8'h00, 1'b0}, 1, 101);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: evict while Leaving keeps the first destination for forwarding
    apply('{1'b0,4'd0,1'b1,2'd1,2'd1,4'd2,8'h00, 3'd2,1'b1,2'd2,2'd1,4'd2,8'h00,1'b0,4'd6});
    apply('{1'b1,4'd11,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd4,1'b1,2'd1,2'd1,4'd11,8'h00,1'b0,4'd3});
    check_out({3'd4, 1'b1, 2'd1, 2'd1, 4'd11, 8'h00, 1'b0}, 3, 102);
    apply('{1'b1,4'd2,1'b0,2'd0,2'd0,4'd0,8'h00, 3'd4,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0,4'd9});
    check_out({3'd4, 1'b0, 2'd0, 2'd0, 4'd0, 8'h00, 1'b0}, 9, 103);
    // R5: an inject arriving while Leaving is forwarded to site 11, not site 2
    apply('{1'b0,4'd0,1'b1,2'd1,2'd0,4'd7,8'h5A, 3'd4,1'b1,2'd1,2'd0,4'd11,8'h5A,1'b0,4'd5});
    check_out({3'd4, 1'b1, 2'd1, 2'd0, 4'd11, 8'h5A, 1'b0}, 5, 104);
    // R11: an acknowledge together with an evict: the acknowledge wins
    apply('{1'b1,4'd3,1'b1,2'd2,2'd0,4'd11,8'h00, 3'd0,1'b0,2'd0,2'd0,4'd0,8'h00,1'b0,4'd11});
    check_out({3'd0, 1'b0, 2'd0, 2'd0, 4'd0, 8'h00, 1'b0}, 11, 105);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule